// File: doc/BRIEF.md
# Z80 I/O Port Select Decoder

This block turns the I/O bus cycles of an 8-bit Z80-style processor into active-low chip selects for five on-board peripherals. The peripherals are a spare/disk slot, a serial controller, a counter/timer, a parallel port and a write-only memory configuration register. Each peripheral owns an aligned group of eight port numbers. Bits 7..3 of the low address byte pick the group. Bits 2..0 pass straight through to the selected device, in their original order.

Selects assert only in a true I/O cycle, which is request low with M1 high. Memory cycles, refresh cycles and interrupt-acknowledge cycles produce no select. Ports from 0x40 upward belong to expansion cards. For these the block raises an expansion flag and a read-direction hint for the buffer of an external bus instead of an on-board select.

The block also merges the processor M1 line with the system reset into the single combined strobe that a parallel-port peripheral expects on its M1 pin. The whole block is combinational. A cycle-kind enum (`CYC_IDLE`, `CYC_IO`, `CYC_INTACK`) names the three bus conditions that the qualifier recognises. There are no state transitions: the kind follows the bus pins directly.

Top module: `z80io_decoder`

## Requirements
- R1: With `iorq_n` high, every select output and `cfg_wr_n` stay high and `ext_sel` stays low. This covers memory reads, memory writes, opcode fetches and refresh.
- R2: A qualified I/O cycle (`iorq_n`=0, `m1_n`=1) at ports 0x00–0x07 drives `spare_cs_n` low.
- R3: A qualified I/O cycle at ports 0x08–0x0F drives `sio_cs_n` low.
- R4: A qualified I/O cycle at ports 0x10–0x17 drives `ctc_cs_n` low.
- R5: A qualified I/O cycle at ports 0x18–0x1F drives `pio_cs_n` low.
- R6: `cfg_wr_n` goes low only in a qualified I/O cycle at ports 0x38–0x3F with `wr_n` low. A read of that group leaves it high.
- R7: Ports 0x20–0x37 and 0x40–0xFF never assert an on-board select.
- R8: `ext_sel` is high exactly during a qualified I/O cycle at a port of 0x40 or above.
- R9: `ext_rd` is high exactly when `ext_sel` is high and `rd_n` is low.
- R10: In an interrupt-acknowledge cycle (`iorq_n`=0 and `m1_n`=0), all selects and `cfg_wr_n` stay high and `ext_sel` stays low, whatever the address.
- R11: `pio_m1_n` is low when `m1_n` is low or `rst_n` is low, and high otherwise. Reset does not block the selects.
- R12: `dev_port` equals address bits 2..0 in the same order: bit 0 to bit 0 and bit 1 to bit 1.
- R13: At most one of `spare_cs_n`, `sio_cs_n`, `ctc_cs_n`, `pio_cs_n` and `cfg_wr_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_lo | input | 8 | Low byte of the address bus (port number) |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Machine cycle one, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rst_n | input | 1 | System reset, active low |
| spare_cs_n | output | 1 | Select for the spare/disk group 0x00–0x07 |
| sio_cs_n | output | 1 | Select for the serial controller 0x08–0x0F |
| ctc_cs_n | output | 1 | Select for the counter/timer 0x10–0x17 |
| pio_cs_n | output | 1 | Select for the parallel port 0x18–0x1F |
| cfg_wr_n | output | 1 | Write clock for the configuration register 0x38–0x3F |
| dev_port | output | 3 | Register index within the selected group |
| ext_sel | output | 1 | Qualified I/O cycle aimed at an expansion port |
| ext_rd | output | 1 | Expansion read: data flows toward the processor |
| pio_m1_n | output | 1 | Merged M1/reset strobe for the parallel port |

## Verification
Two functions can act on the same bus cycle, and the bench drives both combinations on purpose.

The first combination is an I/O cycle at a parallel-port address while reset is held low. The bench expects `pio_cs_n` and `pio_m1_n` to be low together.

The second combination is an interrupt-acknowledge cycle with the address at each device group. In that cycle the merged strobe must go low from M1 while every select is held back. The bench judges every output against a model built from the requirements, across all 256 port numbers and every kind of cycle.

// File: rtl/z80io_pkg.sv
package z80io_pkg;

    localparam int ADDR_W    = 8;
    localparam int GRP_SHIFT = 3;
    localparam int GRP_W     = ADDR_W - GRP_SHIFT;
    localparam int NUM_DEV   = 5;

    // device slots in the select vector
    localparam int D_SPARE = 0;
    localparam int D_SIO   = 1;
    localparam int D_CTC   = 2;
    localparam int D_PIO   = 3;
    localparam int D_CFG   = 4;

    // first port handed to expansion cards
    localparam logic [ADDR_W-1:0] EXT_BASE = 8'h40;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_IO     = 2'd1,
        CYC_INTACK = 2'd2
    } cyc_e;

    // eight-port group number owned by each device slot
    function automatic logic [GRP_W-1:0] dev_group(input int idx);
        logic [GRP_W-1:0] g;
        case (idx)
            D_SPARE: g = GRP_W'(0);
            D_SIO:   g = GRP_W'(1);
            D_CTC:   g = GRP_W'(2);
            D_PIO:   g = GRP_W'(3);
            default: g = GRP_W'(7);
        endcase
        return g;
    endfunction

endpackage

// File: rtl/z80io_cycle_qual.sv
module z80io_cycle_qual
    import z80io_pkg::*;
(
    input  logic iorq_n,
    input  logic m1_n,
    output cyc_e kind,
    output logic io_ok
);

    always_comb begin
        unique case ({iorq_n, m1_n})
            2'b01:   kind = CYC_IO;
            2'b00:   kind = CYC_INTACK;
            default: kind = CYC_IDLE;
        endcase
    end

    assign io_ok = (kind == CYC_IO);

endmodule

// File: rtl/z80io_group_dec.sv
module z80io_group_dec
    import z80io_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int SHIFT  = GRP_SHIFT,
    parameter int NDEV   = NUM_DEV
) (
    input  logic [AW-1:0]   addr,
    input  logic            io_ok,
    output logic [NDEV-1:0] hit,
    output logic            ext_hit
);

    localparam int GW = AW - SHIFT;

    logic [GW-1:0] grp;
    assign grp = addr[AW-1:SHIFT];

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        localparam logic [GW-1:0] MY_GRP = GW'(dev_group(g));
        assign hit[g] = io_ok && (grp == MY_GRP);
    end

    assign ext_hit = io_ok && (addr >= AW'(EXT_BASE));

endmodule

// File: rtl/z80io_m1_merge.sv
module z80io_m1_merge (
    input  logic m1_n,
    input  logic rst_n,
    output logic pio_m1_n
);

    // active-low OR is an AND of the low-true lines
    assign pio_m1_n = m1_n & rst_n;

endmodule

// File: rtl/z80io_decoder.sv
module z80io_decoder
    import z80io_pkg::*;
(
    input  logic [7:0] addr_lo,
    input  logic       iorq_n,
    input  logic       m1_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       rst_n,
    output logic       spare_cs_n,
    output logic       sio_cs_n,
    output logic       ctc_cs_n,
    output logic       pio_cs_n,
    output logic       cfg_wr_n,
    output logic [2:0] dev_port,
    output logic       ext_sel,
    output logic       ext_rd,
    output logic       pio_m1_n
);

    cyc_e               kind;
    logic               io_ok;
    logic [NUM_DEV-1:0] hit;
    logic               ext_hit;

    z80io_cycle_qual u_qual (
        .iorq_n (iorq_n),
        .m1_n   (m1_n),
        .kind   (kind),
        .io_ok  (io_ok)
    );

    z80io_group_dec #(
        .AW    (ADDR_W),
        .SHIFT (GRP_SHIFT),
        .NDEV  (NUM_DEV)
    ) u_dec (
        .addr    (addr_lo),
        .io_ok   (io_ok),
        .hit     (hit),
        .ext_hit (ext_hit)
    );

    z80io_m1_merge u_merge (
        .m1_n     (m1_n),
        .rst_n    (rst_n),
        .pio_m1_n (pio_m1_n)
    );

    assign spare_cs_n = ~hit[D_SPARE];
    assign sio_cs_n   = ~hit[D_SIO];
    assign ctc_cs_n   = ~hit[D_CTC];
    assign pio_cs_n   = ~hit[D_PIO];
    // register clock needs decode and write strobe together
    assign cfg_wr_n   = ~(hit[D_CFG] & ~wr_n);

    // index bits keep their order (serial control/data split on bit 1)
    assign dev_port   = addr_lo[GRP_SHIFT-1:0];

    assign ext_sel    = ext_hit;
    assign ext_rd     = ext_hit & ~rd_n;

endmodule

// File: rtl/z80io_decoder_chk.sv
module z80io_decoder_chk (
    input logic [7:0] addr_lo,
    input logic       iorq_n,
    input logic       m1_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       rst_n,
    input logic       spare_cs_n,
    input logic       sio_cs_n,
    input logic       ctc_cs_n,
    input logic       pio_cs_n,
    input logic       cfg_wr_n,
    input logic       ext_sel,
    input logic       ext_rd,
    input logic       pio_m1_n
);

    logic [4:0] sels_n;
    assign sels_n = {cfg_wr_n, pio_cs_n, ctc_cs_n, sio_cs_n, spare_cs_n};

    always_comb begin
        // R1
        if (iorq_n === 1'b1)
            no_io_quiet_chk: assert (&sels_n && !ext_sel);
        // R10
        if (iorq_n === 1'b0 && m1_n === 1'b0)
            intack_quiet_chk: assert (&sels_n && !ext_sel);
        // R7
        if (addr_lo >= 8'h40 || (addr_lo >= 8'h20 && addr_lo < 8'h38))
            high_range_chk: assert (&sels_n);
        // R6
        if (cfg_wr_n === 1'b0)
            cfg_wr_qual_chk: assert (!wr_n && !iorq_n && m1_n && addr_lo[7:3] == 5'h07);
        // R9
        if (ext_rd === 1'b1)
            ext_rd_qual_chk: assert (ext_sel && !rd_n);
        // R11
        if (rst_n === 1'b0)
            reset_m1_chk: assert (!pio_m1_n);
        // R13
        one_sel_chk: assert ($countones(~sels_n) <= 1);
    end

endmodule

bind z80io_decoder z80io_decoder_chk u_chk (
    .addr_lo    (addr_lo),
    .iorq_n     (iorq_n),
    .m1_n       (m1_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .rst_n      (rst_n),
    .spare_cs_n (spare_cs_n),
    .sio_cs_n   (sio_cs_n),
    .ctc_cs_n   (ctc_cs_n),
    .pio_cs_n   (pio_cs_n),
    .cfg_wr_n   (cfg_wr_n),
    .ext_sel    (ext_sel),
    .ext_rd     (ext_rd),
    .pio_m1_n   (pio_m1_n)
);

// File: tb/z80io_decoder_tb.sv
module z80io_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    // entry = {addr[7:0], iorq_n, m1_n, rd_n, wr_n, rst_n,
    //          spare, sio, ctc, pio, cfg_wr, ext_sel, ext_rd, pio_m1}
    localparam logic [20:0] VEC [NVEC] = '{
        {8'h00, 5'b01011, 8'b01111001},
        {8'h0A, 5'b01011, 8'b10111001},
        {8'h13, 5'b01101, 8'b11011001},
        {8'h1F, 5'b01011, 8'b11101001},
        {8'h38, 5'b01101, 8'b11110001},
        {8'h3C, 5'b01011, 8'b11111001},
        {8'h25, 5'b01101, 8'b11111001},
        {8'h40, 5'b01011, 8'b11111111},
        {8'hFF, 5'b01101, 8'b11111101},
        {8'h10, 5'b00111, 8'b11111000},
        {8'h18, 5'b11011, 8'b11111001},
        {8'h38, 5'b11101, 8'b11111001},
        {8'h18, 5'b01010, 8'b11101000},
        {8'h00, 5'b10011, 8'b11111000},
        {8'h09, 5'b11111, 8'b11111001}
    };

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] addr_lo = 8'h00;
    logic iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rst_n = 1'b0;
    logic spare_cs_n, sio_cs_n, ctc_cs_n, pio_cs_n, cfg_wr_n;
    logic [2:0] dev_port;
    logic ext_sel, ext_rd, pio_m1_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    z80io_decoder dut_i (
        .addr_lo    (addr_lo),
        .iorq_n     (iorq_n),
        .m1_n       (m1_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .rst_n      (rst_n),
        .spare_cs_n (spare_cs_n),
        .sio_cs_n   (sio_cs_n),
        .ctc_cs_n   (ctc_cs_n),
        .pio_cs_n   (pio_cs_n),
        .cfg_wr_n   (cfg_wr_n),
        .dev_port   (dev_port),
        .ext_sel    (ext_sel),
        .ext_rd     (ext_rd),
        .pio_m1_n   (pio_m1_n)
    );

    function automatic logic [7:0] observed();
        return {spare_cs_n, sio_cs_n, ctc_cs_n, pio_cs_n,
                cfg_wr_n, ext_sel, ext_rd, pio_m1_n};
    endfunction

    // expected outputs built from the requirements
    function automatic logic [7:0] model(input logic [7:0] a, input logic [4:0] s);
        logic io, sp, si, ct, pi, cf, ex, xr, pm;
        io = (s[4] == 1'b0) && (s[3] == 1'b1);
        sp = !(io && a <= 8'h07);
        si = !(io && a >= 8'h08 && a <= 8'h0F);
        ct = !(io && a >= 8'h10 && a <= 8'h17);
        pi = !(io && a >= 8'h18 && a <= 8'h1F);
        cf = !(io && a >= 8'h38 && a <= 8'h3F && s[1] == 1'b0);
        ex = io && a >= 8'h40;
        xr = ex && s[2] == 1'b0;
        pm = s[3] && s[0];
        return {sp, si, ct, pi, cf, ex, xr, pm};
    endfunction

    function automatic string tag_for(input logic [7:0] a);
        if (a <= 8'h07) return "R2";
        if (a <= 8'h0F) return "R3";
        if (a <= 8'h17) return "R4";
        if (a <= 8'h1F) return "R5";
        if (a >= 8'h38 && a <= 8'h3F) return "R6";
        if (a >= 8'h40) return "R8";
        return "R7";
    endfunction

    task automatic drive(input logic [7:0] a, input logic [4:0] s);
        @(posedge clk);
        addr_lo = a;
        {iorq_n, m1_n, rd_n, wr_n, rst_n} = s;
        @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%02h ctl=%05b actual=%08b expected=%08b",
                     tag, addr_lo, {iorq_n, m1_n, rd_n, wr_n, rst_n}, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        // reset state, bus idle: merged strobe low, nothing selected (R11, R1)
        drive(8'h18, 5'b11110);
        check8("R11", observed(), 8'b11111000);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][20:13], VEC[i][12:8]);
            check8("R1/R10/table", observed(), VEC[i][7:0]);
        end

        // sweep every port for I/O read and write
        for (int a = 0; a < 256; a++) begin
            drive(8'(a), 5'b01011);
            check8(tag_for(8'(a)), observed(), model(8'(a), 5'b01011));
            n_run++;
            if (dev_port !== a[2:0]) begin // R12
                n_fail++;
                $display("FAIL R12 dev_port actual=%03b expected=%03b", dev_port, a[2:0]);
            end
            drive(8'(a), 5'b01101);
            check8(tag_for(8'(a)), observed(), model(8'(a), 5'b01101));
        end

        // interrupt acknowledge at every group must select nothing (R10)
        for (int g = 0; g < 32; g++) begin
            drive(8'(g * 8 + 3), 5'b00111);
            check8("R10", observed(), 8'b11111000);
        end

        // memory cycles across groups (R1)
        for (int g = 0; g < 32; g++) begin
            drive(8'(g * 8), 5'b11101);
            check8("R1", observed(), 8'b11111001);
        end

        // read of the configuration group leaves its clock high (R6)
        drive(8'h3A, 5'b01011);
        check8("R6", observed(), 8'b11111001);

        // reset during a parallel-port write: select and strobe both low (R11, R5)
        drive(8'h1D, 5'b01100);
        check8("R11", observed(), 8'b11101000);

        // serial index bits keep their order (R12)
        drive(8'h0A, 5'b01011);
        n_run++;
        if (dev_port !== 3'b010 || sio_cs_n !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 dev_port actual=%03b expected=010 sio=%b", dev_port, sio_cs_n);
        end

        // never two selects at once over the sweep (R13)
        for (int a = 0; a < 64; a++) begin
            drive(8'(a), 5'b01101);
            n_run++;
            if ($countones(~{spare_cs_n, sio_cs_n, ctc_cs_n, pio_cs_n, cfg_wr_n}) > 1) begin
                n_fail++;
                $display("FAIL R13 addr=%02h actual=%0d selects expected<=1", a,
                         $countones(~{spare_cs_n, sio_cs_n, ctc_cs_n, pio_cs_n, cfg_wr_n}));
            end
        end

        // expansion write: selected but no read hint (R9)
        drive(8'h80, 5'b01101);
        check8("R9", observed(), 8'b11111101);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule